// File: doc/BRIEF.md
# Multi-Operand Prefix-Sum Unit

This block is a shared arithmetic unit that serves atomic fetch-and-add requests from many parallel thread cores against a small bank of base registers. A request names a base register and carries an increment. It gets back the value the base held just before its own increment was applied, and the base keeps the running total. The usual use is handing out unique slots. For example, every core that has an element to keep adds 1 and receives a distinct write index.

All requests that arrive in the same cycle are combined into one multi-operand operation for each base register. Requests aimed at the same base are ordered by ascending requester index. Each requester receives the base plus the increments of all lower-indexed requesters that targeted the same base. The base then takes the full sum. Software must not rely on which requester gets which slot, so this fixed ordering is a legal choice. Requests aimed at different bases are handled side by side in the same cycle.

A separate master port loads base registers directly. This port is used to set a counter to its starting value before a parallel section.

Top module: `psu_top`

## Requirements
- R1: After reset every base register holds 0 and every response valid bit is 0.
- R2: A request in cycle t produces a response valid pulse for that requester in cycle t+1, carrying the base value that was seen in cycle t.
- R3: Requesters that target the same base in the same cycle are ordered by ascending index. Requester j receives the base plus the sum of the increments of every lower-indexed same-cycle requester with the same select. The lowest such requester receives the base unchanged.
- R4: After a cycle with requests, each targeted base holds its old value plus the sum of all increments aimed at it in that cycle.
- R5: Requests to different bases in the same cycle do not affect one another's results or bases.
- R6: A master write loads the selected base at the next edge and takes precedence over same-cycle requests to that base. Those requests still receive prefixes computed from the old base, but their increments are discarded. Other bases are unaffected by the write.
- R7: Base and increments are 32 bits wide, and all additions wrap modulo 2^32.
- R8: A requester that does not make a request in cycle t has its response valid bit low in cycle t+1.
- R9: Requests in back-to-back cycles see every update from the cycle before, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Per-requester request strobe |
| req_sel | input | NREQ x SW | Per-requester base register select |
| req_inc | input | NREQ x W | Per-requester increment |
| mst_we | input | 1 | Master write strobe |
| mst_sel | input | SW | Master write base select |
| mst_data | input | W | Master write value |
| rsp_valid | output | NREQ | Per-requester response pulse, one cycle after its request |
| rsp_data | output | NREQ x W | Per-requester returned prefix |

## Verification
A wrong base register stays hidden until the next request that reads it. That request then returns the wrong prefix one cycle later. Because of this, the bench keeps probing bases with zero increments, so a corrupted or stale base shows up within a cycle or two. An error in the ordering within a cycle only shows when requesters collide on the same select, so the stimulus forces frequent collisions. An error in the total shows in the first response on the following cycle. A reference model updated on every clock compares every valid bit and every prefix, so a divergence is reported in the cycle it first reaches the ports.

// File: rtl/psu_pkg.sv
package psu_pkg;
    localparam int PSU_DATA_W  = 32;
    localparam int PSU_NREQ    = 4;
    localparam int PSU_NBASE   = 4;

    function automatic int sel_width(input int nbase);
        return (nbase > 1) ? $clog2(nbase) : 1;
    endfunction
endpackage

// File: rtl/psu_scan.sv
module psu_scan
    import psu_pkg::*;
#(
    parameter int NREQ  = PSU_NREQ,
    parameter int NBASE = PSU_NBASE,
    parameter int W     = PSU_DATA_W,
    localparam int SW   = sel_width(NBASE)
) (
    input  logic [NREQ-1:0]            valid,
    input  logic [NREQ-1:0][SW-1:0]    sel,
    input  logic [NREQ-1:0][W-1:0]     inc,
    input  logic [NBASE-1:0][W-1:0]    base,
    output logic [NREQ-1:0][W-1:0]     prefix,
    output logic [NBASE-1:0][W-1:0]    total,
    output logic [NBASE-1:0]           hit
);
    // Running accumulator per base; requesters walked in ascending index order.
    always_comb begin
        total  = base;
        hit    = '0;
        prefix = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (valid[i] && (int'(sel[i]) < NBASE)) begin
                prefix[i]     = total[sel[i]];
                total[sel[i]] = total[sel[i]] + inc[i];
                hit[sel[i]]   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/psu_bank.sv
module psu_bank
    import psu_pkg::*;
#(
    parameter int NBASE = PSU_NBASE,
    parameter int W     = PSU_DATA_W,
    localparam int SW   = sel_width(NBASE)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NBASE-1:0][W-1:0]    nxt,
    input  logic [NBASE-1:0]           hit,
    input  logic                       mst_we,
    input  logic [SW-1:0]              mst_sel,
    input  logic [W-1:0]               mst_data,
    output logic [NBASE-1:0][W-1:0]    base_q
);
    for (genvar b = 0; b < NBASE; b++) begin : g_base
        logic wr_hit;
        assign wr_hit = mst_we && (mst_sel == SW'(b));

        always_ff @(posedge clk) begin
            if (!rst_n)
                base_q[b] <= '0;
            else if (wr_hit)
                base_q[b] <= mst_data;
            else if (hit[b])
                base_q[b] <= nxt[b];
        end

        // R5
        base_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!hit[b] && !wr_hit) |=> $stable(base_q[b]));
    end

    // R6
    mst_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mst_we |=> base_q[$past(mst_sel)] == $past(mst_data));
endmodule

// File: rtl/psu_rsp.sv
module psu_rsp
    import psu_pkg::*;
#(
    parameter int NREQ = PSU_NREQ,
    parameter int W    = PSU_DATA_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NREQ-1:0]         valid,
    input  logic [NREQ-1:0][W-1:0]  prefix,
    output logic [NREQ-1:0]         rsp_valid,
    output logic [NREQ-1:0][W-1:0]  rsp_data
);
    for (genvar i = 0; i < NREQ; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rsp_valid[i] <= 1'b0;
                rsp_data[i]  <= '0;
            end else begin
                rsp_valid[i] <= valid[i];
                if (valid[i])
                    rsp_data[i] <= prefix[i];
            end
        end
    end
endmodule

// File: rtl/psu_top.sv
module psu_top
    import psu_pkg::*;
#(
    parameter int NREQ  = PSU_NREQ,
    parameter int NBASE = PSU_NBASE,
    parameter int W     = PSU_DATA_W,
    localparam int SW   = sel_width(NBASE)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NREQ-1:0]            req_valid,
    input  logic [NREQ-1:0][SW-1:0]    req_sel,
    input  logic [NREQ-1:0][W-1:0]     req_inc,
    input  logic                       mst_we,
    input  logic [SW-1:0]              mst_sel,
    input  logic [W-1:0]               mst_data,
    output logic [NREQ-1:0]            rsp_valid,
    output logic [NREQ-1:0][W-1:0]     rsp_data
);
    logic [NBASE-1:0][W-1:0] base_q;
    logic [NBASE-1:0][W-1:0] total;
    logic [NBASE-1:0]        hit;
    logic [NREQ-1:0][W-1:0]  prefix;

    psu_scan #(.NREQ(NREQ), .NBASE(NBASE), .W(W)) u_scan (
        .valid(req_valid), .sel(req_sel), .inc(req_inc), .base(base_q),
        .prefix(prefix), .total(total), .hit(hit)
    );

    psu_bank #(.NBASE(NBASE), .W(W)) u_bank (
        .clk(clk), .rst_n(rst_n), .nxt(total), .hit(hit),
        .mst_we(mst_we), .mst_sel(mst_sel), .mst_data(mst_data),
        .base_q(base_q)
    );

    psu_rsp #(.NREQ(NREQ), .W(W)) u_rsp (
        .clk(clk), .rst_n(rst_n), .valid(req_valid), .prefix(prefix),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    // R3: the lowest-index requester always sees the untouched base
    first_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid[0] |=> rsp_data[0] == $past(base_q[req_sel[0]]));

    // R3: neighbours on the same base differ by the lower one's increment
    if (NREQ > 1) begin : g_pair
        pair_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[0] && req_valid[1] && req_sel[0] == req_sel[1])
            |=> rsp_data[1] == rsp_data[0] + $past(req_inc[0]));
    end

    // R4: the highest-index requester's prefix plus its increment is the new base
    last_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid[NREQ-1] && !(mst_we && mst_sel == req_sel[NREQ-1]))
        |=> base_q[$past(req_sel[NREQ-1])] == rsp_data[NREQ-1] + $past(req_inc[NREQ-1]));
endmodule

// File: tb/sim_psu_top.sv
module sim_psu_top;
    localparam int NREQ  = 4;
    localparam int NBASE = 4;
    localparam int W     = 32;
    localparam int SW    = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NREQ-1:0]         req_valid = '0;
    logic [NREQ-1:0][SW-1:0] req_sel = '0;
    logic [NREQ-1:0][W-1:0]  req_inc = '0;
    logic                    mst_we = 1'b0;
    logic [SW-1:0]           mst_sel = '0;
    logic [W-1:0]            mst_data = '0;
    logic [NREQ-1:0]         rsp_valid;
    logic [NREQ-1:0][W-1:0]  rsp_data;

    always #10 clk = ~clk;

    psu_top #(.NREQ(NREQ), .NBASE(NBASE), .W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
        .req_inc(req_inc), .mst_we(mst_we), .mst_sel(mst_sel),
        .mst_data(mst_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [W-1:0] mbase [NBASE];
    logic [W-1:0] rng = 32'h1234_5678;

    function automatic logic [W-1:0] next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural model: walk requesters in index order, then apply master write.
    task automatic cycle(input string tag);
        logic [W-1:0] acc [NBASE];
        logic [W-1:0] exp_d [NREQ];
        logic [NREQ-1:0] exp_v;
        for (int b = 0; b < NBASE; b++) acc[b] = mbase[b];
        for (int i = 0; i < NREQ; i++) begin
            exp_v[i] = req_valid[i];
            exp_d[i] = '0;
            if (req_valid[i]) begin
                exp_d[i] = acc[req_sel[i]];
                acc[req_sel[i]] = acc[req_sel[i]] + req_inc[i];
            end
        end
        for (int b = 0; b < NBASE; b++)
            mbase[b] = (mst_we && int'(mst_sel) == b) ? mst_data : acc[b];
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < NREQ; i++) begin
            check(exp_v[i] ? "R2 valid" : "R8 valid", W'(rsp_valid[i]), W'(exp_v[i]));
            if (exp_v[i]) check(tag, rsp_data[i], exp_d[i]);
        end
        req_valid = '0;
        mst_we = 1'b0;
    endtask

    task automatic req(input int i, input int sel, input logic [W-1:0] inc);
        req_valid[i] = 1'b1;
        req_sel[i]   = SW'(sel);
        req_inc[i]   = inc;
    endtask

    task automatic probe_all(input string tag);
        for (int i = 0; i < NREQ; i++) req(i, i, '0);
        cycle(tag);
    endtask

    initial begin
        for (int b = 0; b < NBASE; b++) mbase[b] = '0;
        repeat (3) @(negedge clk);
        // R1: no responses during reset
        for (int i = 0; i < NREQ; i++) check("R1 valid in reset", W'(rsp_valid[i]), '0);
        rst_n = 1'b1;
        probe_all("R1 base after reset");

        // R2: single request returns old base
        req(2, 1, 32'd7);
        cycle("R2 single");
        probe_all("R4 single total");

        // R3: compaction, all add 1 to base 0
        for (int i = 0; i < NREQ; i++) req(i, 0, 32'd1);
        cycle("R3 compaction");
        // R9: back-to-back, sees the updated base
        for (int i = 0; i < NREQ; i++) req(i, 0, 32'(i + 10));
        cycle("R9 back-to-back R3");
        probe_all("R4 merged total");

        // R5: two bases interleaved
        req(0, 2, 32'd5); req(1, 3, 32'd100); req(2, 2, 32'd6); req(3, 3, 32'd200);
        cycle("R5 split bases");
        probe_all("R5 totals");

        // R6: master write precedence
        req(0, 1, 32'd50); req(1, 2, 32'd9);
        mst_we = 1'b1; mst_sel = 2'd1; mst_data = 32'hABCD_0000;
        cycle("R6 write with request");
        probe_all("R6 after write");

        // R7: wrap
        mst_we = 1'b1; mst_sel = 2'd3; mst_data = 32'hFFFF_FFFF;
        cycle("R6 load");
        req(0, 3, 32'd1); req(1, 3, 32'd1); req(3, 3, 32'hFFFF_FFFF);
        cycle("R7 wrap prefixes");
        probe_all("R7 wrap total");

        // Random traffic with many collisions
        for (int n = 0; n < 600; n++) begin
            for (int i = 0; i < NREQ; i++) begin
                logic [W-1:0] r = next_rand();
                req_valid[i] = r[0] | r[1];
                req_sel[i]   = r[3:2];
                req_inc[i]   = r[4] ? next_rand() : W'(r[9:6]);
            end
            begin
                logic [W-1:0] r = next_rand();
                mst_we   = (r[3:0] == 4'h0);
                mst_sel  = r[5:4];
                mst_data = next_rand();
            end
            cycle("R3 random");
        end
        probe_all("R4 final totals");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule